// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital front end of a 16-bit voltage-output DAC. A host writes to it over a 3-wire serial link. The three wires are an active-low frame select, a serial clock and a data line. All three are sampled by a faster system clock, so falling edges of the serial clock are detected in the system-clock domain. Each frame carries 24 bits. The block keeps the 16-bit two's-complement sample code and a 2-bit power-mode field, and it updates both together when the frame completes.

If frame select rises before the last bit, the partial frame is dropped. A sticky flag then records that a frame was aborted. The stored code is sent to the resistor-string core as offset binary. A one-cycle strobe marks every committed update.

Top module: `sdac_frame_rx`

## Requirements
- R1: After reset, `core_code` is 0x8000 (midscale), `pwr_mode` is 00, and both `upd_pulse` and `abort_seen` are 0. These values hold until the first complete frame.
- R2: A frame is 24 bits, shifted in most significant bit first, one bit per falling edge of `ser_clk` while `frame_n` is low. Bits 23 to 18 have no effect on any output.
- R3: Frame bits 17:16 drive `pwr_mode` directly. The encodings are 00 normal, 01 output tied low through a small resistance, 10 output tied low through a large resistance, and 11 output floating.
- R4: Frame bits 15:0 are a two's-complement code. `core_code` is that code with bit 15 inverted: 0x0000 gives 0x8000, 0x7FFF gives 0xFFFF, 0x8000 gives 0x0000, and 0xFFFF gives 0x7FFF.
- R5: Code and mode change together, and only on a completed frame. The change appears at the second rising `clk` edge after the 24th low level of `ser_clk` is first present at the input.
- R6: If `frame_n` rises after 1 to 23 falling edges, the partial frame is discarded, `core_code` and `pwr_mode` keep their values, and `abort_seen` becomes 1 and stays 1 until reset. The next full frame is then received normally.
- R7: Falling edges of `ser_clk` after the 24th, while `frame_n` stays low, have no effect. A new frame starts only after `frame_n` goes high and then low again.
- R8: Selecting a power-down mode does not clear or force the code. `core_code` still reflects the code carried in that frame.
- R9: `upd_pulse` is high for exactly one `clk` cycle per committed frame, in the same cycle in which the new code and mode first appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edges |
| ser_dat | input | 1 | Serial data, MSB first |
| core_code | output | 16 | Offset-binary code to the resistor string |
| pwr_mode | output | 2 | Power-mode select to the output stage |
| upd_pulse | output | 1 | One-cycle strobe on each committed frame |
| abort_seen | output | 1 | Sticky flag set by an aborted frame |

## Verification
The inputs pass through one register stage and then an edge detector. The committed code, the mode and the strobe are therefore due at the second rising clock edge after the 24th serial-clock fall is driven. The bench checks that `upd_pulse` is still low one edge after that fall and high after the second edge. The scoreboard monitor samples on the falling clock edge and pops one expected word for each strobe, so an update that arrives late, early or unexpectedly shows up as a mismatch. Abort checks and extra-edge checks wait several cycles after `frame_n` rises and then read the outputs and the sticky flag directly.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int FRAME_BITS = 24;
    localparam int CODE_W     = 16;
    localparam int MODE_W     = 2;

    typedef enum logic [MODE_W-1:0] {
        PM_ACTIVE  = 2'b00,
        PM_PULL_LO = 2'b01,
        PM_PULL_HI = 2'b10,
        PM_FLOAT   = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        pwr_mode_e         mode;
        logic [CODE_W-1:0] code;
    } dac_word_t;

    // two's complement to offset binary: flip the sign bit
    function automatic logic [CODE_W-1:0] to_offset(input logic [CODE_W-1:0] c);
        return {~c[CODE_W-1], c[CODE_W-2:0]};
    endfunction

endpackage

// File: rtl/sdac_in_sample.sv
module sdac_in_sample #(
    parameter int IN_STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_n,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic sck_fall,
    output logic sel_hi,
    output logic dat_s
);
    logic [IN_STAGES-1:0] sck_p, sel_p, dat_p;
    logic                 sck_prev;

    generate
        if (IN_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_p <= 1'b1;
                    sel_p <= 1'b1;
                    dat_p <= 1'b0;
                end else begin
                    sck_p <= ser_clk;
                    sel_p <= frame_n;
                    dat_p <= ser_dat;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_p <= '1;
                    sel_p <= '1;
                    dat_p <= '0;
                end else begin
                    sck_p <= {sck_p[IN_STAGES-2:0], ser_clk};
                    sel_p <= {sel_p[IN_STAGES-2:0], frame_n};
                    dat_p <= {dat_p[IN_STAGES-2:0], ser_dat};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sck_prev <= 1'b1;
        else     sck_prev <= sck_p[IN_STAGES-1];
    end

    assign sck_fall = sck_prev & ~sck_p[IN_STAGES-1];
    assign sel_hi   = sel_p[IN_STAGES-1];
    assign dat_s    = dat_p[IN_STAGES-1];

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
#(
    parameter int FBITS = FRAME_BITS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sck_fall,
    input  logic      sel_hi,
    input  logic      dat_s,
    output logic      commit,
    output logic      abort,
    output dac_word_t word
);
    localparam int CNT_W = $clog2(FBITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FBITS - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FBITS);

    logic [FBITS-1:0] shift_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic [FBITS-1:0] shift_nx;
    logic             take;

    assign take     = sck_fall && !sel_hi && !done_q;
    assign shift_nx = {shift_q[FBITS-2:0], dat_s};
    assign commit   = take && (cnt_q == LAST);
    assign abort    = sel_hi && !done_q && (cnt_q != '0);

    assign word.mode = pwr_mode_e'(shift_nx[CODE_W+MODE_W-1:CODE_W]);
    assign word.code = shift_nx[CODE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || sel_hi) begin
            shift_q <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else if (take) begin
            shift_q <= shift_nx;
            cnt_q   <= commit ? FULL : cnt_q + 1'b1;
            done_q  <= commit;
        end
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);
    assert_clear_on_release_R6: assert property (@(posedge clk) disable iff (rst)
        sel_hi |=> (cnt_q == '0) && !done_q);
    assert_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (done_q && sck_fall && !sel_hi) |=> $stable(shift_q) && done_q);

endmodule

// File: rtl/sdac_out_regs.sv
module sdac_out_regs
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              abort,
    input  dac_word_t         word,
    output logic [CODE_W-1:0] core_code,
    output logic [MODE_W-1:0] pwr_mode,
    output logic              upd_pulse,
    output logic              abort_seen
);
    dac_word_t held_q;
    logic      upd_q;
    logic      abort_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q.code <= '0;
            held_q.mode <= PM_ACTIVE;
            upd_q       <= 1'b0;
            abort_q     <= 1'b0;
        end else begin
            upd_q <= commit;
            if (commit) held_q <= word;
            if (abort)  abort_q <= 1'b1;
        end
    end

    assign core_code  = to_offset(held_q.code);
    assign pwr_mode   = held_q.mode;
    assign upd_pulse  = upd_q;
    assign abort_seen = abort_q;

    assert_hold_without_commit_R5: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(held_q));
    assert_abort_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        abort_q |=> abort_q);
    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        upd_q |=> !upd_q);

endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx
    import sdac_pkg::*;
#(
    parameter int IN_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [CODE_W-1:0] core_code,
    output logic [MODE_W-1:0] pwr_mode,
    output logic              upd_pulse,
    output logic              abort_seen
);
    logic      sck_fall, sel_hi, dat_s;
    logic      commit, abort;
    dac_word_t word;

    sdac_in_sample #(.IN_STAGES(IN_STAGES)) u_in (
        .clk(clk), .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .sck_fall(sck_fall), .sel_hi(sel_hi), .dat_s(dat_s)
    );

    sdac_shifter #(.FBITS(FRAME_BITS)) u_shift (
        .clk(clk), .rst(rst), .sck_fall(sck_fall), .sel_hi(sel_hi),
        .dat_s(dat_s), .commit(commit), .abort(abort), .word(word)
    );

    sdac_out_regs u_out (
        .clk(clk), .rst(rst), .commit(commit), .abort(abort), .word(word),
        .core_code(core_code), .pwr_mode(pwr_mode), .upd_pulse(upd_pulse),
        .abort_seen(abort_seen)
    );

    assert_reset_midscale_R1: assert property (@(posedge clk)
        $past(rst) |-> (core_code == 16'h8000) && (pwr_mode == 2'b00) && !abort_seen);
    assert_change_with_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !upd_pulse |=> upd_pulse || ($stable(core_code) && $stable(pwr_mode)));

endmodule

// File: tb/sdac_frame_rx_tb_top.sv
module sdac_frame_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        ser_clk = 1'b1;
    logic        ser_dat = 1'b0;
    logic [15:0] core_code;
    logic [1:0]  pwr_mode;
    logic        upd_pulse;
    logic        abort_seen;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [15:0] code;
        logic [1:0]  mode;
        string       req;
    } exp_t;

    exp_t        sb[$];
    exp_t        e;
    logic [15:0] last_code = 16'h8000;
    logic [1:0]  last_mode = 2'b00;
    logic        upd_prev  = 1'b0;
    bit          done      = 1'b0;

    always #2 clk = ~clk;

    sdac_frame_rx dut_i (
        .clk(clk), .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .core_code(core_code), .pwr_mode(pwr_mode),
        .upd_pulse(upd_pulse), .abort_seen(abort_seen)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // monitor: pop one expected word per strobe
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (upd_pulse && upd_prev)
                chk(0, "R9", "strobe longer than one cycle", 1, 0);
            if (upd_pulse) begin
                if (sb.size() == 0) begin
                    chk(0, "R7", "unexpected update", int'(core_code), int'(last_code));
                end else begin
                    e = sb.pop_front();
                    chk(core_code == e.code, e.req, "core_code", int'(core_code), int'(e.code));
                    chk(pwr_mode == e.mode, e.req, "pwr_mode", int'(pwr_mode), int'(e.mode));
                end
            end
            upd_prev = upd_pulse;
        end
    end

    // driver: nbits falls in the frame, extra falls beyond the 24th
    task automatic send_frame(input logic [23:0] w, input int nbits,
                              input int extra, input string req);
        exp_t x;
        if (nbits >= 24) begin
            x.code = {~w[15], w[14:0]};
            x.mode = w[17:16];
            x.req  = req;
            sb.push_back(x);
            last_code = x.code;
            last_mode = x.mode;
        end
        frame_n = 1'b0;
        cyc(3);
        for (int i = 0; i < nbits; i++) begin
            ser_dat = w[23-i];
            cyc(3);
            ser_clk = 1'b0;
            if (i == 23) begin
                cyc(1);
                chk(upd_pulse == 1'b0, "R5", "strobe one edge after last fall", int'(upd_pulse), 0);
                cyc(1);
                chk(upd_pulse == 1'b1, "R5", "strobe two edges after last fall", int'(upd_pulse), 1);
                cyc(1);
            end else begin
                cyc(3);
            end
            ser_clk = 1'b1;
        end
        for (int k = 0; k < extra; k++) begin
            ser_dat = k[0];
            cyc(3);
            ser_clk = 1'b0;
            cyc(3);
            ser_clk = 1'b1;
        end
        cyc(3);
        frame_n = 1'b1;
        cyc(6);
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(2);
        // R1 reset state
        chk(core_code == 16'h8000, "R1", "reset core_code", int'(core_code), 'h8000);
        chk(pwr_mode == 2'b00, "R1", "reset pwr_mode", int'(pwr_mode), 0);
        chk(upd_pulse == 1'b0, "R1", "reset upd_pulse", int'(upd_pulse), 0);
        chk(abort_seen == 1'b0, "R1", "reset abort_seen", int'(abort_seen), 0);

        // R2/R3: ignored top bits all ones, mode 01
        send_frame(24'hFD1234, 24, 0, "R2");
        // R4 codes at the extremes
        send_frame(24'h027FFF, 24, 0, "R4");
        send_frame(24'h008000, 24, 0, "R4");
        chk(core_code == 16'h0000, "R4", "most negative code", int'(core_code), 0);

        // R6 abort after 10 bits
        send_frame(24'h03ABCD, 10, 0, "R6");
        chk(abort_seen == 1'b1, "R6", "abort flag", int'(abort_seen), 1);
        chk(core_code == last_code, "R6", "code after abort", int'(core_code), int'(last_code));
        chk(pwr_mode == last_mode, "R6", "mode after abort", int'(pwr_mode), int'(last_mode));

        // R3/R8: floating output mode with code -1
        send_frame(24'h03FFFF, 24, 0, "R3");
        chk(core_code == 16'h7FFF, "R8", "code kept in power-down", int'(core_code), 'h7FFF);
        chk(abort_seen == 1'b1, "R6", "abort flag sticky", int'(abort_seen), 1);

        // R7 extra falls after the 24th
        send_frame(24'h000001, 24, 6, "R7");
        chk(core_code == 16'h8001, "R7", "code after extra edges", int'(core_code), 'h8001);
        chk(pwr_mode == 2'b00, "R7", "mode after extra edges", int'(pwr_mode), 0);

        // R6 boundary: abort after 23 bits
        send_frame(24'h015555, 23, 0, "R6");
        chk(core_code == 16'h8001, "R6", "code after 23-bit abort", int'(core_code), 'h8001);
        chk(pwr_mode == 2'b00, "R6", "mode after 23-bit abort", int'(pwr_mode), 0);

        // R8 large-resistance mode keeps carried code
        send_frame(24'h02ABCD, 24, 0, "R8");
        chk(core_code == 16'h2BCD, "R8", "code in pull-high-R mode", int'(core_code), 'h2BCD);
        chk(pwr_mode == 2'b10, "R3", "mode 10", int'(pwr_mode), 2);

        cyc(4);
        chk(sb.size() == 0, "R5", "pending expected updates", sb.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            chk(0, "R5", "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule